// File: doc/BRIEF.md
# Graphic LCD Configuration Command Decoder

This block sits behind the byte-wide command path of a graphic LCD controller. It takes command bytes and keeps the controller's configuration registers up to date. A byte is taken on every rising clock edge where `cmd_valid` is high. Every register value is driven straight out to the drive, bias and addressing logic that use it.

Most commands carry their operand in the low bits of the opcode byte, so they take effect in one byte. Four commands take two bytes. The first byte names a target register: display start line, display offset, multiplex ratio or line-inversion count. The next accepted byte is taken as the value for that target, whatever its bit pattern. Opcodes in the reserved ranges change nothing and raise a one-cycle error pulse.

Top module: `gcfg_cmd_decode`

## Requirements
- R1: After reset, the outputs take these values: column pointer 0, master mode (`slave_mode`=0), regulator ratio 000, all three power enables 0, start line 0, display offset 0, multiplex ratio 159, inversion count 0, bias code 110 and `cmd_err` 0.
- R2: A byte in 0x00–0x0F writes its bits [3:0] into `col_addr[3:0]`. A byte in 0x10–0x17 writes its bits [2:0] into `col_addr[6:4]`. The other pointer bits keep their value in both cases.
- R3: Byte 0x18 selects master mode (`slave_mode`=0) and byte 0x19 selects slave mode (`slave_mode`=1).
- R4: A byte in 0x20–0x27 writes its bits [2:0] into `reg_ratio`.
- R5: A byte in 0x28–0x2F writes bit 2 to `boost_en`, bit 1 to `regul_en` and bit 0 to `buffer_en`.
- R6: A byte in 0x50–0x57 writes its bits [2:0] into `bias_code`.
- R7: A byte in 0x40–0x4F starts a two-byte command, and bits [3:2] of that byte pick the target: 00 start line, 01 display offset, 10 multiplex ratio, 11 inversion count. The next accepted byte is written whole to the target.
- R8: For the inversion target, only bits [5:0] of the value byte are stored in `inv_lines`.
- R9: The byte that follows a two-byte opcode is always treated as data, never as a command, even if it matches an opcode. It ends the pending state. Cycles with `cmd_valid` low do not end the pending state.
- R10: An opcode byte in 0x1A–0x1F, 0x30–0x3F or 0x58–0x5F leaves every register unchanged and makes `cmd_err` high for exactly one cycle. An opcode byte in 0x60–0xFF leaves every register unchanged and does not raise `cmd_err`.
- R11: A new value shows on the outputs after the clock edge that accepts the byte, and not before it. While `cmd_valid` is low, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| cmd_valid | input | 1 | Marks `cmd_byte` as valid in this cycle |
| cmd_byte | input | 8 | Command or data byte |
| col_addr | output | 7 | Column address pointer |
| slave_mode | output | 1 | 0 = master, 1 = slave |
| reg_ratio | output | 3 | Regulator resistor ratio code |
| boost_en | output | 1 | Voltage booster enable |
| regul_en | output | 1 | Regulator enable |
| buffer_en | output | 1 | Output buffer enable |
| start_line | output | 8 | Display start line |
| disp_offset | output | 8 | Display offset |
| mux_ratio | output | 8 | Multiplex ratio (line count minus one) |
| inv_lines | output | 6 | Line-inversion count, 0 = off |
| bias_code | output | 3 | Bias selection code |
| cmd_err | output | 1 | One-cycle pulse on a reserved opcode |

## Verification
The bench sends value bytes that look like opcodes (0x4C, 0x20, 0xC5). A decoder that treats such a byte as a command would change a second register or leave the pending state armed. Idle cycles are placed between the two bytes of a pair, which catches a design that drops the pending state when `cmd_valid` is low. The bench writes the two halves of the column pointer in turn and checks that neither write clobbers the other half. The reserved ranges and the undecoded range 0x60–0xFF are both exercised, which catches an error pulse that fires on the wrong set of bytes, stays high for more than one cycle, or comes with a register write.

// File: rtl/gcfg_pkg.sv
package gcfg_pkg;
  typedef enum logic [3:0] {
    OPC_COL_LO,
    OPC_COL_HI,
    OPC_MODE,
    OPC_RATIO,
    OPC_POWER,
    OPC_PAIR,
    OPC_BIAS,
    OPC_RSVD,
    OPC_NONE
  } opclass_e;

  typedef enum logic [1:0] {
    PSEL_START  = 2'd0,
    PSEL_OFFSET = 2'd1,
    PSEL_MUX    = 2'd2,
    PSEL_INV    = 2'd3
  } pair_sel_e;
endpackage

// File: rtl/gcfg_classify.sv
module gcfg_classify
  import gcfg_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] byte_i,
  output opclass_e          cls_o,
  output pair_sel_e         sel_o
);
  always_comb begin
    unique case (byte_i[7:3])
      5'b00000, 5'b00001: cls_o = OPC_COL_LO;
      5'b00010:           cls_o = OPC_COL_HI;
      5'b00011:           cls_o = (byte_i[2:1] == 2'b00) ? OPC_MODE : OPC_RSVD;
      5'b00100:           cls_o = OPC_RATIO;
      5'b00101:           cls_o = OPC_POWER;
      5'b00110, 5'b00111: cls_o = OPC_RSVD;
      5'b01000, 5'b01001: cls_o = OPC_PAIR;
      5'b01010:           cls_o = OPC_BIAS;
      5'b01011:           cls_o = OPC_RSVD;
      default:            cls_o = OPC_NONE;
    endcase
    sel_o = pair_sel_e'(byte_i[3:2]);
  end
endmodule

// File: rtl/gcfg_pending.sv
module gcfg_pending
  import gcfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      valid_i,
  input  opclass_e  cls_i,
  input  pair_sel_e sel_i,
  output logic      pend_o,
  output pair_sel_e sel_o
);
  logic      pend_d, pend_q;
  pair_sel_e sel_d, sel_q;
  logic      sel_en;

  always_comb begin
    pend_d = pend_q;
    sel_en = 1'b0;
    if (valid_i) begin
      if (pend_q) begin
        pend_d = 1'b0;
      end else if (cls_i == OPC_PAIR) begin
        pend_d = 1'b1;
        sel_en = 1'b1;
      end
    end
    sel_d = sel_en ? sel_i : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      sel_q  <= PSEL_START;
    end else begin
      pend_q <= pend_d;
      sel_q  <= sel_d;
    end
  end

  assign pend_o = pend_q;
  assign sel_o  = sel_q;

  AST_DATA_ENDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && pend_q) |=> !pend_q); // R9
  AST_IDLE_KEEPS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i && pend_q) |=> pend_q); // R9
  AST_PAIR_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !pend_q && cls_i == OPC_PAIR) |=> pend_q); // R7
endmodule

// File: rtl/gcfg_regs.sv
module gcfg_regs
  import gcfg_pkg::*;
#(
  parameter int         BYTE_W    = 8,
  parameter int         COL_W     = 7,
  parameter int         INV_W     = 6,
  parameter logic [7:0] MUX_RST   = 8'd159,
  parameter logic [2:0] BIAS_RST  = 3'b110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  opclass_e          cls_i,
  input  logic              pend_i,
  input  pair_sel_e         psel_i,
  output logic [COL_W-1:0]  col_o,
  output logic              slave_o,
  output logic [2:0]        ratio_o,
  output logic [2:0]        pwr_o,
  output logic [BYTE_W-1:0] start_o,
  output logic [BYTE_W-1:0] offset_o,
  output logic [BYTE_W-1:0] mux_o,
  output logic [INV_W-1:0]  inv_o,
  output logic [2:0]        bias_o
);
  localparam int COL_HI_W = COL_W - 4;

  logic [COL_W-1:0]  col_d;
  logic              slave_d;
  logic [2:0]        ratio_d, pwr_d, bias_d;
  logic [BYTE_W-1:0] start_d, offset_d, mux_d;
  logic [INV_W-1:0]  inv_d;
  logic              cmd_en, dat_en;

  assign cmd_en = valid_i && !pend_i;
  assign dat_en = valid_i &&  pend_i;

  always_comb begin
    col_d    = col_o;
    slave_d  = slave_o;
    ratio_d  = ratio_o;
    pwr_d    = pwr_o;
    bias_d   = bias_o;
    start_d  = start_o;
    offset_d = offset_o;
    mux_d    = mux_o;
    inv_d    = inv_o;
    if (dat_en) begin
      unique case (psel_i)
        PSEL_START:  start_d  = byte_i;
        PSEL_OFFSET: offset_d = byte_i;
        PSEL_MUX:    mux_d    = byte_i;
        PSEL_INV:    inv_d    = byte_i[INV_W-1:0];
      endcase
    end else if (cmd_en) begin
      case (cls_i)
        OPC_COL_LO: col_d[3:0]     = byte_i[3:0];
        OPC_COL_HI: col_d[COL_W-1:4] = byte_i[COL_HI_W-1:0];
        OPC_MODE:   slave_d        = byte_i[0];
        OPC_RATIO:  ratio_d        = byte_i[2:0];
        OPC_POWER:  pwr_d          = byte_i[2:0];
        OPC_BIAS:   bias_d         = byte_i[2:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_o    <= '0;
      slave_o  <= 1'b0;
      ratio_o  <= 3'b000;
      pwr_o    <= 3'b000;
      bias_o   <= BIAS_RST;
      start_o  <= '0;
      offset_o <= '0;
      mux_o    <= MUX_RST;
      inv_o    <= '0;
    end else begin
      col_o    <= col_d;
      slave_o  <= slave_d;
      ratio_o  <= ratio_d;
      pwr_o    <= pwr_d;
      bias_o   <= bias_d;
      start_o  <= start_d;
      offset_o <= offset_d;
      mux_o    <= mux_d;
      inv_o    <= inv_d;
    end
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(col_o) && $stable(slave_o) && $stable(ratio_o) && $stable(pwr_o)
                  && $stable(bias_o) && $stable(start_o) && $stable(offset_o)
                  && $stable(mux_o) && $stable(inv_o))); // R11
  AST_RSVD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && (cls_i == OPC_RSVD || cls_i == OPC_NONE)) |=>
      ($stable(col_o) && $stable(slave_o) && $stable(ratio_o) && $stable(pwr_o)
       && $stable(bias_o) && $stable(start_o) && $stable(offset_o)
       && $stable(mux_o) && $stable(inv_o))); // R10
  AST_DATA_NOT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    dat_en |=> ($stable(col_o) && $stable(slave_o) && $stable(ratio_o)
                && $stable(pwr_o) && $stable(bias_o))); // R9
  AST_COL_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && cls_i == OPC_COL_HI) |=> $stable(col_o[3:0])); // R2
endmodule

// File: rtl/gcfg_cmd_decode.sv
module gcfg_cmd_decode
  import gcfg_pkg::*;
#(
  parameter int         BYTE_W   = 8,
  parameter int         COL_W    = 7,
  parameter int         INV_W    = 6,
  parameter int         SYNC_N   = 2,
  parameter logic [7:0] MUX_RST  = 8'd159,
  parameter logic [2:0] BIAS_RST = 3'b110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [BYTE_W-1:0] cmd_byte,
  output logic [COL_W-1:0]  col_addr,
  output logic              slave_mode,
  output logic [2:0]        reg_ratio,
  output logic              boost_en,
  output logic              regul_en,
  output logic              buffer_en,
  output logic [BYTE_W-1:0] start_line,
  output logic [BYTE_W-1:0] disp_offset,
  output logic [BYTE_W-1:0] mux_ratio,
  output logic [INV_W-1:0]  inv_lines,
  output logic [2:0]        bias_code,
  output logic              cmd_err
);
  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[SYNC_N-1];

  opclass_e  cls;
  pair_sel_e sel_in, sel_q;
  logic      pend;
  logic [2:0] pwr;
  logic      err_d, err_q;

  gcfg_classify #(.BYTE_W(BYTE_W)) u_classify (
    .byte_i (cmd_byte),
    .cls_o  (cls),
    .sel_o  (sel_in)
  );

  gcfg_pending u_pending (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .valid_i (cmd_valid),
    .cls_i   (cls),
    .sel_i   (sel_in),
    .pend_o  (pend),
    .sel_o   (sel_q)
  );

  gcfg_regs #(
    .BYTE_W(BYTE_W), .COL_W(COL_W), .INV_W(INV_W),
    .MUX_RST(MUX_RST), .BIAS_RST(BIAS_RST)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .valid_i  (cmd_valid),
    .byte_i   (cmd_byte),
    .cls_i    (cls),
    .pend_i   (pend),
    .psel_i   (sel_q),
    .col_o    (col_addr),
    .slave_o  (slave_mode),
    .ratio_o  (reg_ratio),
    .pwr_o    (pwr),
    .start_o  (start_line),
    .offset_o (disp_offset),
    .mux_o    (mux_ratio),
    .inv_o    (inv_lines),
    .bias_o   (bias_code)
  );

  assign boost_en  = pwr[2];
  assign regul_en  = pwr[1];
  assign buffer_en = pwr[0];

  assign err_d = cmd_valid && !pend && (cls == OPC_RSVD);

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) err_q <= 1'b0;
    else            err_q <= err_d;
  end
  assign cmd_err = err_q;

  AST_ERR_FROM_OPCODE: assert property (@(posedge clk) disable iff (!rst_n_int)
    cmd_err |-> $past(cmd_valid && !pend)); // R10
  AST_ERR_IDLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n_int)
    !cmd_valid |=> !cmd_err); // R10
endmodule

// File: tb/gcfg_cmd_decode_bench.sv
module gcfg_cmd_decode_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic [6:0] col_addr;
  logic       slave_mode, boost_en, regul_en, buffer_en, cmd_err;
  logic [2:0] reg_ratio, bias_code;
  logic [7:0] start_line, disp_offset, mux_ratio;
  logic [5:0] inv_lines;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gcfg_cmd_decode u_gcfg_cmd_decode (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .col_addr(col_addr), .slave_mode(slave_mode), .reg_ratio(reg_ratio),
    .boost_en(boost_en), .regul_en(regul_en), .buffer_en(buffer_en),
    .start_line(start_line), .disp_offset(disp_offset), .mux_ratio(mux_ratio),
    .inv_lines(inv_lines), .bias_code(bias_code), .cmd_err(cmd_err)
  );

  // entry: {byte, field, expected, err, requirement number}
  // fields: 0 col, 1 mode, 2 ratio, 3 power, 4 start, 5 offset, 6 mux, 7 inv, 8 bias
  localparam int NVEC = 21;
  localparam logic [24:0] VEC [NVEC] = '{
    {8'h05, 4'd0, 8'h05, 1'b0, 4'd2},  // R2 low nibble
    {8'h13, 4'd0, 8'h35, 1'b0, 4'd2},  // R2 upper bits keep low
    {8'h0A, 4'd0, 8'h3A, 1'b0, 4'd2},  // R2 low keeps upper
    {8'h19, 4'd1, 8'h01, 1'b0, 4'd3},  // R3 slave
    {8'h18, 4'd1, 8'h00, 1'b0, 4'd3},  // R3 master
    {8'h25, 4'd2, 8'h05, 1'b0, 4'd4},  // R4
    {8'h2D, 4'd3, 8'h05, 1'b0, 4'd5},  // R5 booster+buffer
    {8'h53, 4'd8, 8'h03, 1'b0, 4'd6},  // R6
    {8'h40, 4'd4, 8'h00, 1'b0, 4'd7},  // R7 opcode only, no write yet
    {8'h7E, 4'd4, 8'h7E, 1'b0, 4'd7},  // R7 start line
    {8'h45, 4'd5, 8'h00, 1'b0, 4'd7},  // R7
    {8'h4C, 4'd5, 8'h4C, 1'b0, 4'd9},  // R9 opcode-like data
    {8'h4A, 4'd6, 8'h9F, 1'b0, 4'd7},  // R7
    {8'h20, 4'd6, 8'h20, 1'b0, 4'd9},  // R9 data resembling ratio cmd
    {8'h4F, 4'd7, 8'h00, 1'b0, 4'd7},  // R7
    {8'hC5, 4'd7, 8'h05, 1'b0, 4'd8},  // R8 low six bits
    {8'h1C, 4'd0, 8'h3A, 1'b1, 4'd10}, // R10 reserved
    {8'h33, 4'd2, 8'h05, 1'b1, 4'd10}, // R10 reserved
    {8'h5A, 4'd8, 8'h03, 1'b1, 4'd10}, // R10 reserved
    {8'h80, 4'd0, 8'h3A, 1'b0, 4'd10}, // R10 undecoded, no error
    {8'h17, 4'd0, 8'h7A, 1'b0, 4'd2}   // R2
  };

  function automatic logic [7:0] field_val(input logic [3:0] f);
    case (f)
      4'd0: field_val = {1'b0, col_addr};
      4'd1: field_val = {7'd0, slave_mode};
      4'd2: field_val = {5'd0, reg_ratio};
      4'd3: field_val = {5'd0, boost_en, regul_en, buffer_en};
      4'd4: field_val = start_line;
      4'd5: field_val = disp_offset;
      4'd6: field_val = mux_ratio;
      4'd7: field_val = {2'd0, inv_lines};
      default: field_val = {5'd0, bias_code};
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    cmd_byte  = b;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic check_reset_state();
    check("R1 col", {25'd0, col_addr}, 32'd0);
    check("R1 mode", {31'd0, slave_mode}, 32'd0);
    check("R1 ratio", {29'd0, reg_ratio}, 32'd0);
    check("R1 power", {29'd0, boost_en, regul_en, buffer_en}, 32'd0);
    check("R1 start", {24'd0, start_line}, 32'd0);
    check("R1 offset", {24'd0, disp_offset}, 32'd0);
    check("R1 mux", {24'd0, mux_ratio}, 32'd159);
    check("R1 inv", {26'd0, inv_lines}, 32'd0);
    check("R1 bias", {29'd0, bias_code}, 32'd6);
    check("R1 err", {31'd0, cmd_err}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset_state();

    for (int i = 0; i < NVEC; i++) begin
      logic [24:0] v;
      string tag;
      v = VEC[i];
      send(v[24:17]);
      tag = $sformatf("R%0d vec%0d", v[3:0], i);
      check(tag, {24'd0, field_val(v[16:13])}, {24'd0, v[12:5]});
      check({tag, " err"}, {31'd0, cmd_err}, {31'd0, v[4]});
      // idle cycle between pair bytes must not drop the pending state (R9)
      @(negedge clk);
    end

    // R10: error pulse lasts one cycle only
    send(8'h3F);
    check("R10 err high", {31'd0, cmd_err}, 32'd1);
    @(negedge clk);
    check("R10 err one cycle", {31'd0, cmd_err}, 32'd0);

    // R10: reserved byte as data is not an error (R9)
    send(8'h48);
    send(8'h1B);
    check("R9 data no err", {31'd0, cmd_err}, 32'd0);
    check("R9 data to mux", {24'd0, mux_ratio}, 32'h1B);
    check("R9 mode untouched", {31'd0, slave_mode}, 32'd0);

    // R11: not visible before the accepting edge, visible after
    @(negedge clk);
    cmd_byte  = 8'h2A;
    cmd_valid = 1'b1;
    #1;
    check("R11 before edge", {29'd0, boost_en, regul_en, buffer_en}, 32'd5);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R11 after edge", {29'd0, boost_en, regul_en, buffer_en}, 32'd2);

    // R11: valid low, byte toggles, nothing changes
    cmd_byte = 8'h0F;
    repeat (3) @(negedge clk);
    check("R11 idle col", {25'd0, col_addr}, 32'h7A);

    // R1: asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    check_reset_state();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset_state();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule